// File: doc/BRIEF.md
# Dual-Channel ATA Interrupt Status Register

This block gathers the interrupt state of the two ATA channels of a bus-master disk controller into one byte-wide mode register. A rising edge on a channel's drive interrupt line latches a pending flag for that channel. Software clears a flag by writing a one to its bit. A per-channel block bit, set after reset, keeps a latched flag from reaching the channel's interrupt output.

A second output per channel qualifies the pending flag with the interrupt flag of that channel's DMA status byte. Driver code uses it to decide whether a finished transfer raised the interrupt. The two lowest bits of the register are write-only controls. They reach an output port and always read back as zero.

Top module: `ide_irq_status`

## Requirements
- R1: After reset the register reads 0x30: both pending flags are 0, both block bits are 1, and irq_o, irq_test_o and ctl_o are all 0.
- R2: A rising edge on drv_irq_i[c] sets channel c's pending flag. The flag is read at bit 2 for channel 0 and bit 3 for channel 1, and is visible after the clock edge at which the high level is first sampled. A line held high does not set the flag again once it has been cleared.
- R3: A register write with a 1 at a channel's pending bit clears that flag. A 0 at that position leaves it as it was.
- R4: If a rising edge and a clearing write for the same channel fall in the same cycle, the flag ends up set.
- R5: Register writes load the block bits: bit 4 for channel 0 and bit 5 for channel 1. Reads return the written values.
- R6: irq_o[c] is high exactly when channel c's pending flag is 1 and its block bit is 0.
- R7: irq_test_o[c] is high exactly when channel c's pending flag is 1 and dma_intr_i[c] (the INTR bit, bit 2, of that channel's DMA status byte) is 1.
- R8: Register bits 1:0 are write-only. A write loads them into ctl_o, and they read back as 0. Bits 7:6 are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_irq_i | input | 2 | Drive interrupt lines, one per channel, synchronous to clk |
| dma_intr_i | input | 2 | INTR flag of each channel's DMA status byte |
| reg_wr_i | input | 1 | Write strobe for the mode register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read value of the mode register |
| irq_o | output | 2 | Interrupt request per channel, after the block bits |
| irq_test_o | output | 2 | Pending flag qualified by the DMA INTR flag |
| ctl_o | output | 2 | Write-only control bits 1:0 |

## Verification
The bench goes after four corner cases:
- A rising edge and a clearing write in the same cycle. A design that gives the clear priority would lose an interrupt.
- A drive line held high across a clear. A level-sensitive design would set the flag again at once and trap software in an interrupt storm.
- Writes of zero to the pending bits. A design that treats those bits as plain storage would wipe a pending flag.
- Readback of the write-only bits and of bits 7:6. A design that returns them would feed software stale control values.

Seeded random traffic covers mixed masks and DMA flags between these directed cases.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CH   = 2;
  localparam int REG_W    = 8;
  localparam int PEND_LSB = 2;
  localparam int BLK_LSB  = 4;
  localparam int CTL_W    = 2;
  localparam logic [REG_W-1:0] RESET_VALUE =
    REG_W'(((1 << NUM_CH) - 1) << BLK_LSB);
endpackage

// File: rtl/ide_irq_edge.sv
module ide_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_i;
  end

  assign rise_o = line_i & ~prev_q;
endmodule

// File: rtl/ide_irq_chan.sv
module ide_irq_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic wr_en_i,
  input  logic clr_i,
  input  logic blk_d_i,
  output logic pend_o,
  output logic blk_o
);
  logic pend_q, pend_d;
  logic blk_q, blk_d;

  // A set in the same cycle as a clear wins, so no edge is lost.
  always_comb begin
    pend_d = pend_q;
    blk_d  = blk_q;
    if (wr_en_i) begin
      if (clr_i) pend_d = 1'b0;
      blk_d = blk_d_i;
    end
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      blk_q  <= 1'b1;
    end else begin
      pend_q <= pend_d;
      blk_q  <= blk_d;
    end
  end

  assign pend_o = pend_q;
  assign blk_o  = blk_q;
endmodule

// File: rtl/ide_irq_status.sv
module ide_irq_status
  import ide_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       drv_irq_i,
  input  logic [1:0]       dma_intr_i,
  input  logic             reg_wr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic [1:0]       irq_o,
  output logic [1:0]       irq_test_o,
  output logic [1:0]       ctl_o
);
  logic [NUM_CH-1:0] rise, pend, blk;
  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic              unused_wr_hi;

  assign unused_wr_hi = ^reg_wdata_i[REG_W-1:BLK_LSB+NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_irq_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (drv_irq_i[c]),
      .rise_o (rise[c])
    );
    ide_irq_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (rise[c]),
      .wr_en_i (reg_wr_i),
      .clr_i   (reg_wdata_i[PEND_LSB+c]),
      .blk_d_i (reg_wdata_i[BLK_LSB+c]),
      .pend_o  (pend[c]),
      .blk_o   (blk[c])
    );
  end

  always_comb begin
    ctl_d = ctl_q;
    if (reg_wr_i) ctl_d = reg_wdata_i[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[PEND_LSB +: NUM_CH] = pend;
    reg_rdata_o[BLK_LSB  +: NUM_CH] = blk;
  end

  assign irq_o      = pend & ~blk;
  assign irq_test_o = pend & dma_intr_i;
  assign ctl_o      = ctl_q;
endmodule

// File: rtl/ide_irq_status_chk.sv
module ide_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] drv_irq_i,
  input logic [1:0] dma_intr_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic [1:0] irq_o,
  input logic [1:0] irq_test_o,
  input logic [1:0] ctl_o
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    // R2 and R4: a rise always leaves the flag set, clearing write or not
    assert_rise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_irq_i[c] && !$past(drv_irq_i[c])) |=> reg_rdata_o[2+c]);
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i[2+c] && !drv_irq_i[c]) |=> !reg_rdata_o[2+c]);
    assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && !reg_wdata_i[2+c] && reg_rdata_o[2+c]) |=> reg_rdata_o[2+c]);
    assert_block_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i |=> (reg_rdata_o[4+c] == $past(reg_wdata_i[4+c])));
    assert_irq_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] == (reg_rdata_o[2+c] && !reg_rdata_o[4+c]));
    assert_irq_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_test_o[c] == (reg_rdata_o[2+c] && dma_intr_i[c]));
  end

  assert_wo_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[1:0] == 2'b00) && (reg_rdata_o[7:6] == 2'b00));
  assert_ctl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (ctl_o == $past(reg_wdata_i[1:0])));
endmodule

bind ide_irq_status ide_irq_status_chk u_chk (.*);

// File: tb/ide_irq_status_tb.sv
module ide_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] drv_irq_i, dma_intr_i;
  logic       reg_wr_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic [1:0] irq_o, irq_test_o, ctl_o;

  int tests = 0;
  int fails = 0;

  // Bench model of the register state
  logic [1:0] m_pend, m_blk, m_ctl, m_prev;

  always #5 clk = ~clk;

  ide_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .drv_irq_i(drv_irq_i), .dma_intr_i(dma_intr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .irq_test_o(irq_test_o), .ctl_o(ctl_o)
  );

  function automatic logic [7:0] exp_rdata();
    return {2'b00, m_blk, m_pend, 2'b00};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    check("R2/R3 pending", {6'b0, reg_rdata_o[3:2]}, {6'b0, m_pend});
    check("R5 block", {6'b0, reg_rdata_o[5:4]}, {6'b0, m_blk});
    check("R8 readback", {4'b0, reg_rdata_o[7:6], reg_rdata_o[1:0]}, 8'h00);
    check("R8 ctl", {6'b0, ctl_o}, {6'b0, m_ctl});
    check("R6 irq", {6'b0, irq_o}, {6'b0, m_pend & ~m_blk});
    check("R7 test", {6'b0, irq_test_o}, {6'b0, m_pend & dma_intr_i});
  endtask

  // Called at a negedge: applies inputs, advances the model, checks at the next negedge
  task automatic cycle(logic [1:0] drv, logic [1:0] dma, logic wr, logic [7:0] wd);
    logic [1:0] rise;
    drv_irq_i = drv; dma_intr_i = dma; reg_wr_i = wr; reg_wdata_i = wd;
    rise = drv & ~m_prev;
    if (wr) begin
      m_pend = m_pend & ~wd[3:2];
      m_blk  = wd[5:4];
      m_ctl  = wd[1:0];
    end
    m_pend = m_pend | rise;
    m_prev = drv;
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst_n = 1'b0; drv_irq_i = 2'b00; dma_intr_i = 2'b00;
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
    m_pend = 2'b00; m_blk = 2'b11; m_ctl = 2'b00; m_prev = 2'b00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset rdata", reg_rdata_o, 8'h30);
    check("R1 reset outs", {2'b0, irq_o, irq_test_o, ctl_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: rise on channel 0 sets bit 2; unblock to see irq (R6)
    cycle(2'b01, 2'b00, 1'b1, 8'h00);
    check("R2 ch0 set", {7'b0, reg_rdata_o[2]}, 8'h01);
    // R7: INTR qualifies the test output
    cycle(2'b01, 2'b01, 1'b0, 8'h00);
    check("R7 test ch0", {6'b0, irq_test_o}, 8'h01);
    // R3: writing 0 keeps the flag, writing 1 clears it while the line is held high
    cycle(2'b01, 2'b00, 1'b1, 8'h00);
    check("R3 w0 keeps", {7'b0, reg_rdata_o[2]}, 8'h01);
    cycle(2'b01, 2'b00, 1'b1, 8'h04);
    check("R3 w1 clears", {7'b0, reg_rdata_o[2]}, 8'h00);
    cycle(2'b01, 2'b00, 1'b0, 8'h00);
    check("R2 held level no reset", {7'b0, reg_rdata_o[2]}, 8'h00);
    // R4: rise on channel 1 together with its clear
    cycle(2'b10, 2'b00, 1'b1, 8'h08);
    check("R4 set wins", {7'b0, reg_rdata_o[3]}, 8'h01);
    // R5 / R8: block bits and write-only bits
    cycle(2'b10, 2'b00, 1'b1, 8'hE3);
    check("R5 blocks", {6'b0, reg_rdata_o[5:4]}, 8'h02);
    check("R8 ctl load", {6'b0, ctl_o}, 8'h03);
    check("R6 ch1 blocked", {6'b0, irq_o}, 8'h00);

    // Seeded random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] wd;
      wd = 8'($urandom());
      cycle(2'($urandom()), 2'($urandom()), 1'(($urandom() % 4) == 0), wd);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule